// File: doc/BRIEF.md
# I/O Translation Unit Control Register File

This block is the software-visible register set of an I/O address translation unit. A host reaches it over a simple word-addressed bus. It has a write strobe, a read strobe, a word index, 32-bit write data and registered read data. Each register applies its own write mask and forced-one bits. One register only accumulates bits. The block also decodes the mapping-range field of the control register into the start address of the translation window, and exports that address, the enable bit and the page-table base to the translator.

A fault-capture port lets the translator report a failed access. The status and address registers load in one cycle and a registered interrupt line rises. Software acknowledges the interrupt by reading or writing either fault register. Word indices that match no named register go to a small tagged scratch store. That store keeps written values unmasked and returns zero for any location it does not hold.

Top module: `ioxlat_csr`

## Requirements
- R1: After reset, reads return the following:
  - control = {VERSION, 24'h0}
  - fault status = 0x00800000
  - arbiter enable = 0x00000003
  - arbitration enable = 0x00000008
  - mask ID = 0x23000000
  - every other register and unwritten scratch location = 0
  - windowStart is 0 and xlatEnable is 0.
- R2: A write to control (index 0x000) stores (data & 0x1D) | {VERSION, 24'h0}. xlatEnable follows bit 0 of the stored value.
- R3: A control write sets windowStart from data bits [4:2]. Code 0 gives 0xFF000000, and each higher code doubles the window, up to code 7 which gives 0x80000000.
- R4: A base write (index 0x001) keeps data & 0x07FFFC00 and drives tableBase. A write to slot configuration k (index 0x404+k, k=0..3) keeps data & 0x00010003. The TLB flush (0x005) and page flush (0x006) registers store data unmasked.
- R5: A write to fault status (index 0x400) stores (data & 0xFF0FFFFF) | 0x00800000. A write to fault address (index 0x401) stores data unmasked.
- R6: A write to arbiter enable (index 0x402) stores (data & 0x801F000F) | 0x1. A write to arbitration enable (index 0x800) stores (data & 0x001F0000) | 0x8.
- R7: A write to mask ID (index 0xC06) ORs data & 0x00FFFFFF into the held value. No write clears a bit.
- R8: A cycle with faultValid high loads fault status with 0xC0820000, plus 0x00040000 when faultIsRead is 1. The same cycle loads fault address with faultAddr and raises irq on the next clock.
- R9: A read or write of fault status or fault address clears irq on the next clock. Accesses to other registers leave irq unchanged.
- R10: A fault capture wins over a software write to the fault registers in the same cycle, and over an interrupt clear in the same cycle.
- R11: A write to any other index stores the data unmasked in a scratch store of SCRATCH_DEPTH entries. A read of a held index returns its data, and a read of any other index returns 0. When the store is full, a new index replaces the entry allocated earliest.
- R12: Read data for a read strobe in one cycle appears on busRdData after the next clock and holds until the next read. A read in the same cycle as a write returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Word index (byte offset >> 2) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| faultValid | input | 1 | Translator reports a fault this cycle |
| faultIsRead | input | 1 | Faulting access was a read |
| faultAddr | input | 32 | Faulting page address |
| windowStart | output | 32 | Start address of translation window |
| xlatEnable | output | 1 | Translation enable bit of control |
| tableBase | output | 32 | Masked page-table base register |
| irq | output | 1 | Registered fault interrupt |

## Verification
The bench builds the block with SCRATCH_DEPTH = 4 and VERSION = 0x5A. The shallow scratch store makes eviction reachable: the random traffic cycles through five unlisted indices, so entries are replaced over and over and stale reads must return 0. The non-zero version byte shows whether the constant is merged into control on reset and on every write. Random writes and reads are mixed with fault captures and compared against a bench model. Directed cases cover the two extreme range codes, mask-ID accumulation, and a fault that collides with a software write and an acknowledge.

// File: rtl/ioxlat_pkg.sv
package ioxlat_pkg;

  localparam int REG_W     = 32;
  localparam int NUM_SLOTS = 4;

  // word indices (byte offset >> 2); decoded by software, so fixed
  localparam logic [11:0] IDX_CTRL   = 12'h000;
  localparam logic [11:0] IDX_BASE   = 12'h001;
  localparam logic [11:0] IDX_TLBFL  = 12'h005;
  localparam logic [11:0] IDX_PGFL   = 12'h006;
  localparam logic [11:0] IDX_FSTAT  = 12'h400;
  localparam logic [11:0] IDX_FADDR  = 12'h401;
  localparam logic [11:0] IDX_ARBEN  = 12'h402;
  localparam logic [11:0] IDX_SLOT0  = 12'h404;
  localparam logic [11:0] IDX_SBARB  = 12'h800;
  localparam logic [11:0] IDX_MASKID = 12'hC06;

  localparam logic [REG_W-1:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [REG_W-1:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [REG_W-1:0] FSTAT_KEEP  = 32'hFF0F_FFFF;
  localparam logic [REG_W-1:0] FSTAT_SET   = 32'h0080_0000;
  localparam logic [REG_W-1:0] ARBEN_KEEP  = 32'h801F_000F;
  localparam logic [REG_W-1:0] ARBEN_SET   = 32'h0000_0001;
  localparam logic [REG_W-1:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [REG_W-1:0] SBARB_KEEP  = 32'h001F_0000;
  localparam logic [REG_W-1:0] SBARB_SET   = 32'h0000_0008;
  localparam logic [REG_W-1:0] MASKID_KEEP = 32'h00FF_FFFF;

  localparam logic [REG_W-1:0] ARBEN_RST   = 32'h0000_0003;
  localparam logic [REG_W-1:0] MASKID_RST  = 32'h2300_0000;

  localparam logic [REG_W-1:0] FAULT_CODE  = 32'hC082_0000;
  localparam logic [REG_W-1:0] FAULT_RDBIT = 32'h0004_0000;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_BASE, SEL_TLBFL, SEL_PGFL, SEL_FSTAT, SEL_FADDR,
    SEL_ARBEN, SEL_SLOT, SEL_SBARB, SEL_MASKID, SEL_SCRATCH
  } regSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
    logic [1:0] slotIdx;
    logic    irqClear;
  } csrStrobe_t;

endpackage

// File: rtl/ioxlat_ctrl.sv
module ioxlat_ctrl
  import ioxlat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output csrStrobe_t        stb
);

  localparam logic [ADDR_W-1:0] SLOT_MASK = ~ADDR_W'(NUM_SLOTS - 1);

  regSel_e selNext;

  always_comb begin
    selNext = SEL_SCRATCH;
    if (busAddr == ADDR_W'(IDX_CTRL))        selNext = SEL_CTRL;
    else if (busAddr == ADDR_W'(IDX_BASE))   selNext = SEL_BASE;
    else if (busAddr == ADDR_W'(IDX_TLBFL))  selNext = SEL_TLBFL;
    else if (busAddr == ADDR_W'(IDX_PGFL))   selNext = SEL_PGFL;
    else if (busAddr == ADDR_W'(IDX_FSTAT))  selNext = SEL_FSTAT;
    else if (busAddr == ADDR_W'(IDX_FADDR))  selNext = SEL_FADDR;
    else if (busAddr == ADDR_W'(IDX_ARBEN))  selNext = SEL_ARBEN;
    else if ((busAddr & SLOT_MASK) == ADDR_W'(IDX_SLOT0)) selNext = SEL_SLOT;
    else if (busAddr == ADDR_W'(IDX_SBARB))  selNext = SEL_SBARB;
    else if (busAddr == ADDR_W'(IDX_MASKID)) selNext = SEL_MASKID;
  end

  always_comb begin
    stb.wrEn     = busWrEn;
    stb.rdEn     = busRdEn;
    stb.sel      = selNext;
    stb.slotIdx  = busAddr[1:0];
    stb.irqClear = (busWrEn || busRdEn) &&
                   (selNext == SEL_FSTAT || selNext == SEL_FADDR);
  end

endmodule

// File: rtl/ioxlat_scratch.sv
module ioxlat_scratch
  import ioxlat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  entVld;
  logic [ADDR_W-1:0] entTag  [DEPTH];
  logic [REG_W-1:0]  entData [DEPTH];
  logic [PTR_W-1:0]  allocPtr;
  logic              hit;
  logic [PTR_W-1:0]  hitIdx;

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    rdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entVld[i] && entTag[i] == addr) begin
        hit    = 1'b1;
        hitIdx = PTR_W'(i);
        rdData = entData[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic take;
    assign take = wrEn && (hit ? (hitIdx == PTR_W'(g)) : (allocPtr == PTR_W'(g)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entVld[g]  <= 1'b0;
        entTag[g]  <= '0;
        entData[g] <= '0;
      end else if (take) begin
        entVld[g]  <= 1'b1;
        entTag[g]  <= addr;
        entData[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allocPtr <= '0;
    end else if (wrEn && !hit) begin
      if (allocPtr == PTR_W'(DEPTH - 1)) allocPtr <= '0;
      else                               allocPtr <= allocPtr + 1'b1;
    end
  end

endmodule

// File: rtl/ioxlat_dp.sv
module ioxlat_dp
  import ioxlat_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  csrStrobe_t       stb,
  input  logic [REG_W-1:0] busWrData,
  input  logic [REG_W-1:0] scratchRd,
  input  logic             faultValid,
  input  logic             faultIsRead,
  input  logic [REG_W-1:0] faultAddr,
  output logic [REG_W-1:0] busRdData,
  output logic [REG_W-1:0] windowStart,
  output logic             xlatEnable,
  output logic [REG_W-1:0] tableBase,
  output logic             irq
);

  localparam logic [REG_W-1:0] VER_WORD = {VERSION, 24'h0};

  logic [REG_W-1:0] ctrlReg, baseReg, tlbFlReg, pgFlReg;
  logic [REG_W-1:0] fstatReg, faddrReg, arbEnReg, sbArbReg, maskIdReg;
  logic [REG_W-1:0] slotReg [NUM_SLOTS];
  logic [REG_W-1:0] rdMux;

  function automatic logic [REG_W-1:0] windowOf(input logic [2:0] code);
    return 32'hFFFF_FFFF << (24 + int'(code));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg     <= VER_WORD;
      baseReg     <= '0;
      tlbFlReg    <= '0;
      pgFlReg     <= '0;
      fstatReg    <= FSTAT_SET;
      faddrReg    <= '0;
      arbEnReg    <= ARBEN_RST;
      sbArbReg    <= SBARB_SET;
      maskIdReg   <= MASKID_RST;
      windowStart <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slotReg[i] <= '0;
    end else begin
      if (stb.wrEn) begin
        case (stb.sel)
          SEL_CTRL: begin
            ctrlReg     <= (busWrData & CTRL_KEEP) | VER_WORD;
            windowStart <= windowOf(busWrData[4:2]);
          end
          SEL_BASE:   baseReg   <= busWrData & BASE_KEEP;
          SEL_TLBFL:  tlbFlReg  <= busWrData;
          SEL_PGFL:   pgFlReg   <= busWrData;
          SEL_FSTAT:  fstatReg  <= (busWrData & FSTAT_KEEP) | FSTAT_SET;
          SEL_FADDR:  faddrReg  <= busWrData;
          SEL_ARBEN:  arbEnReg  <= (busWrData & ARBEN_KEEP) | ARBEN_SET;
          SEL_SLOT:   slotReg[stb.slotIdx] <= busWrData & SLOT_KEEP;
          SEL_SBARB:  sbArbReg  <= (busWrData & SBARB_KEEP) | SBARB_SET;
          SEL_MASKID: maskIdReg <= maskIdReg | (busWrData & MASKID_KEEP);
          default: ;
        endcase
      end
      // capture port has the last word on the fault registers
      if (faultValid) begin
        fstatReg <= FAULT_CODE | (faultIsRead ? FAULT_RDBIT : '0);
        faddrReg <= faultAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq <= 1'b0;
    else if (faultValid) irq <= 1'b1;
    else if (stb.irqClear) irq <= 1'b0;
  end

  always_comb begin
    case (stb.sel)
      SEL_CTRL:   rdMux = ctrlReg;
      SEL_BASE:   rdMux = baseReg;
      SEL_TLBFL:  rdMux = tlbFlReg;
      SEL_PGFL:   rdMux = pgFlReg;
      SEL_FSTAT:  rdMux = fstatReg;
      SEL_FADDR:  rdMux = faddrReg;
      SEL_ARBEN:  rdMux = arbEnReg;
      SEL_SLOT:   rdMux = slotReg[stb.slotIdx];
      SEL_SBARB:  rdMux = sbArbReg;
      SEL_MASKID: rdMux = maskIdReg;
      default:    rdMux = scratchRd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        busRdData <= '0;
    else if (stb.rdEn) busRdData <= rdMux;
  end

  assign xlatEnable = ctrlReg[0];
  assign tableBase  = baseReg;

endmodule

// File: rtl/ioxlat_csr.sv
module ioxlat_csr
  import ioxlat_pkg::*;
#(
  parameter int         ADDR_W        = 12,
  parameter int         SCRATCH_DEPTH = 4,
  parameter logic [7:0] VERSION       = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              faultValid,
  input  logic              faultIsRead,
  input  logic [31:0]       faultAddr,
  output logic [31:0]       windowStart,
  output logic              xlatEnable,
  output logic [31:0]       tableBase,
  output logic              irq
);

  csrStrobe_t       stb;
  logic [REG_W-1:0] scratchRd;
  logic             scratchWr;

  ioxlat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  assign scratchWr = stb.wrEn && (stb.sel == SEL_SCRATCH);

  ioxlat_scratch #(.ADDR_W(ADDR_W), .DEPTH(SCRATCH_DEPTH)) u_scratch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (scratchWr),
    .addr   (busAddr),
    .wrData (busWrData),
    .rdData (scratchRd)
  );

  ioxlat_dp #(.VERSION(VERSION)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .busWrData   (busWrData),
    .scratchRd   (scratchRd),
    .faultValid  (faultValid),
    .faultIsRead (faultIsRead),
    .faultAddr   (faultAddr),
    .busRdData   (busRdData),
    .windowStart (windowStart),
    .xlatEnable  (xlatEnable),
    .tableBase   (tableBase),
    .irq         (irq)
  );

endmodule

// File: rtl/ioxlat_csr_chk.sv
module ioxlat_csr_chk
  import ioxlat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [4:0]        wrLow,
  input logic [31:23]      rdTop,
  input logic              rdBit0,
  input logic              faultValid,
  input logic [31:0]       windowStart,
  input logic              xlatEnable,
  input logic              irq
);

  logic faultRegHit;
  assign faultRegHit = (busAddr == ADDR_W'(IDX_FSTAT)) || (busAddr == ADDR_W'(IDX_FADDR));

  assert_ctrl_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_W'(IDX_CTRL)) |=> (xlatEnable == $past(wrLow[0])));

  assert_window_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_W'(IDX_CTRL)) |=>
      (windowStart == (32'hFFFF_FFFF << (24 + int'($past(wrLow[4:2]))))));

  assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (windowStart[23:0] == 24'h0));

  assert_fstat_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == ADDR_W'(IDX_FSTAT)) |=> rdTop[23]);

  assert_arben_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == ADDR_W'(IDX_ARBEN)) |=> rdBit0);

  assert_maskid_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busAddr == ADDR_W'(IDX_MASKID)) |=> (rdTop[31:24] == 8'h23));

  assert_fault_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    faultValid |=> irq);

  assert_access_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!faultValid && (busWrEn || busRdEn) && faultRegHit) |=> !irq);

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!faultValid && !((busWrEn || busRdEn) && faultRegHit)) |=> (irq == $past(irq)));

endmodule

bind ioxlat_csr ioxlat_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busAddr     (busAddr),
  .wrLow       (busWrData[4:0]),
  .rdTop       (busRdData[31:23]),
  .rdBit0      (busRdData[0]),
  .faultValid  (faultValid),
  .windowStart (windowStart),
  .xlatEnable  (xlatEnable),
  .irq         (irq)
);

// File: tb/test_ioxlat_csr.sv
`timescale 1ns/1ps
module test_ioxlat_csr;

  localparam logic [7:0] VER = 8'h5A;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic faultValid = 1'b0, faultIsRead = 1'b0;
  logic [31:0] faultAddr = '0;
  logic [31:0] windowStart, tableBase;
  logic xlatEnable, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ioxlat_csr #(.ADDR_W(12), .SCRATCH_DEPTH(DEPTH), .VERSION(VER)) i_ioxlat_csr (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .faultValid(faultValid), .faultIsRead(faultIsRead), .faultAddr(faultAddr),
    .windowStart(windowStart), .xlatEnable(xlatEnable), .tableBase(tableBase),
    .irq(irq)
  );

  // bench model
  logic [31:0] mCtrl, mBase, mTlb, mPg, mFst, mFar, mAer, mSbarb, mMask, mWin;
  logic [31:0] mSlot [4];
  logic        mIrq;
  logic [11:0] sTag [DEPTH];
  logic [31:0] sData [DEPTH];
  bit          sVld [DEPTH];
  int          sPtr;

  task automatic modelReset();
    mCtrl = {VER, 24'h0}; mBase = 0; mTlb = 0; mPg = 0; mFst = 32'h0080_0000;
    mFar = 0; mAer = 32'h3; mSbarb = 32'h8; mMask = 32'h2300_0000; mWin = 0;
    for (int i = 0; i < 4; i++) mSlot[i] = 0;
    for (int i = 0; i < DEPTH; i++) begin sVld[i] = 0; sTag[i] = 0; sData[i] = 0; end
    sPtr = 0; mIrq = 0;
  endtask

  function automatic logic [31:0] winOf(input logic [2:0] c);
    case (c)
      3'd0: return 32'hFF00_0000;  3'd1: return 32'hFE00_0000;
      3'd2: return 32'hFC00_0000;  3'd3: return 32'hF800_0000;
      3'd4: return 32'hF000_0000;  3'd5: return 32'hE000_0000;
      3'd6: return 32'hC000_0000;  default: return 32'h8000_0000;
    endcase
  endfunction

  function automatic bit isFaultReg(input logic [11:0] a);
    return a == 12'h400 || a == 12'h401;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h000: return mCtrl;   12'h001: return mBase;
      12'h005: return mTlb;    12'h006: return mPg;
      12'h400: return mFst;    12'h401: return mFar;
      12'h402: return mAer;    12'h800: return mSbarb;
      12'hC06: return mMask;
      12'h404, 12'h405, 12'h406, 12'h407: return mSlot[a[1:0]];
      default: begin
        for (int i = 0; i < DEPTH; i++) if (sVld[i] && sTag[i] == a) return sData[i];
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string reqOf(input logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h001, 12'h005, 12'h006, 12'h404, 12'h405, 12'h406, 12'h407: return "R4";
      12'h400, 12'h401: return "R5";
      12'h402, 12'h800: return "R6";
      12'hC06: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h000: begin mCtrl = (d & 32'h1D) | {VER, 24'h0}; mWin = winOf(d[4:2]); end
      12'h001: mBase = d & 32'h07FF_FC00;
      12'h005: mTlb = d;
      12'h006: mPg = d;
      12'h400: mFst = (d & 32'hFF0F_FFFF) | 32'h0080_0000;
      12'h401: mFar = d;
      12'h402: mAer = (d & 32'h801F_000F) | 32'h1;
      12'h800: mSbarb = (d & 32'h001F_0000) | 32'h8;
      12'hC06: mMask = mMask | (d & 32'h00FF_FFFF);
      12'h404, 12'h405, 12'h406, 12'h407: mSlot[a[1:0]] = d & 32'h0001_0003;
      default: begin
        bit found = 0;
        for (int i = 0; i < DEPTH; i++)
          if (sVld[i] && sTag[i] == a) begin sData[i] = d; found = 1; end
        if (!found) begin
          sVld[sPtr] = 1; sTag[sPtr] = a; sData[sPtr] = d;
          sPtr = (sPtr + 1) % DEPTH;
        end
      end
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, sample after the next posedge
  task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] d, input bit f, input bit fRd,
                      input logic [31:0] fA);
    logic [31:0] expRd;
    expRd = modelRead(a);                       // R12: old value
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    faultValid = f; faultIsRead = fRd; faultAddr = fA;
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; faultValid = 0;
    if (wr) modelWrite(a, d);
    if (f) begin                                // R10: capture wins
      mFst = 32'hC082_0000 | (fRd ? 32'h0004_0000 : 32'h0);
      mFar = fA;
      mIrq = 1;
    end else if ((wr || rd) && isFaultReg(a)) mIrq = 0;
    if (rd) check(busRdData == expRd, reqOf(a), "read data", busRdData, expRd);
    check(irq == mIrq, f ? "R8" : "R9", "irq", {31'h0, irq}, {31'h0, mIrq});
    check(windowStart == mWin, "R3", "windowStart", windowStart, mWin);
    check(xlatEnable == mCtrl[0], "R2", "xlatEnable", {31'h0, xlatEnable}, {31'h0, mCtrl[0]});
    check(tableBase == mBase, "R4", "tableBase", tableBase, mBase);
  endtask

  task automatic rd(input logic [11:0] a);  step(0, 1, a, 0, 0, 0, 0); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); step(1, 0, a, d, 0, 0, 0); endtask

  logic [11:0] addrPool [18] = '{12'h000, 12'h001, 12'h005, 12'h006, 12'h400,
    12'h401, 12'h402, 12'h404, 12'h405, 12'h406, 12'h407, 12'h800, 12'hC06,
    12'h002, 12'h3FF, 12'h810, 12'hC07, 12'hFFF};

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 0, "R1", "irq after reset", {31'h0, irq}, 0);
    check(windowStart == 0, "R1", "window after reset", windowStart, 0);
    check(xlatEnable == 0, "R1", "enable after reset", {31'h0, xlatEnable}, 0);
    foreach (addrPool[i]) begin
      rd(addrPool[i]);
      check(busRdData == modelRead(addrPool[i]), "R1", "reset read", busRdData, modelRead(addrPool[i]));
    end

    // R2 R3 extreme range codes
    wr(12'h000, 32'hFFFF_FFE3);   // code 0, enable on
    check(windowStart == 32'hFF00_0000, "R3", "code 0", windowStart, 32'hFF00_0000);
    rd(12'h000);
    check(busRdData == 32'h5A00_0001, "R2", "ctrl masked", busRdData, 32'h5A00_0001);
    wr(12'h000, 32'h0000_001C);   // code 7
    check(windowStart == 32'h8000_0000, "R3", "code 7", windowStart, 32'h8000_0000);

    // R7 accumulate
    wr(12'hC06, 32'hFF00_00F0);
    wr(12'hC06, 32'h0000_000F);
    wr(12'hC06, 32'h0000_0000);
    rd(12'hC06);
    check(busRdData == 32'h2300_00FF, "R7", "mask id sticky", busRdData, 32'h2300_00FF);

    // R8 R9 fault, unrelated access keeps irq, read clears
    step(0, 0, 12'h000, 0, 1, 1, 32'h1234_5000);
    check(irq == 1, "R8", "irq set", {31'h0, irq}, 1);
    rd(12'h402);
    check(irq == 1, "R9", "irq kept on other read", {31'h0, irq}, 1);
    rd(12'h400);
    check(busRdData == 32'hC086_0000, "R8", "status read fault", busRdData, 32'hC086_0000);
    check(irq == 0, "R9", "irq cleared by read", {31'h0, irq}, 0);

    // R10 fault collides with software write to status
    step(1, 0, 12'h400, 32'h0000_0000, 1, 0, 32'hABCD_E000);
    rd(12'h400);
    check(busRdData == 32'hC082_0000, "R10", "fault beats write", busRdData, 32'hC082_0000);
    // irq cleared by that read; now fault together with acknowledge write
    step(1, 0, 12'h401, 32'h1, 1, 0, 32'h7777_7000);
    check(irq == 1, "R10", "fault beats clear", {31'h0, irq}, 1);
    wr(12'h401, 32'h5);
    check(irq == 0, "R9", "write clears irq", {31'h0, irq}, 0);

    // R11 scratch: fill, evict oldest, unwritten reads zero
    rd(12'h123);
    check(busRdData == 0, "R11", "unwritten zero", busRdData, 0);
    for (int i = 0; i < DEPTH + 1; i++) wr(12'h100 + 12'(i), 32'hA000_0000 + i);
    rd(12'h100);
    check(busRdData == 0, "R11", "oldest evicted", busRdData, 0);
    rd(12'h104);
    check(busRdData == 32'hA000_0004, "R11", "newest held", busRdData, 32'hA000_0004);

    // R12 read and write same cycle returns old value
    step(1, 1, 12'h005, 32'hDEAD_BEEF, 0, 0, 0);
    rd(12'h005);
    check(busRdData == 32'hDEAD_BEEF, "R12", "new value next read", busRdData, 32'hDEAD_BEEF);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      a = addrPool[$urandom_range(0, 17)];
      step($urandom_range(0, 1), $urandom_range(0, 1), a, $urandom(),
           ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom() & 32'hFFFF_F000);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule